// File: doc/BRIEF.md
# Peripheral Power Cycle Sequencer

This block sits on the host side of a parallel-port style link and switches an external peripheral off or on through a single supply-enable control line. Each switch also puts the rest of the port into a known state. On a power-off request it parks every port line at its low-power level. On a power-on request it leaves the port idle and ready for enhanced parallel port transfers. A complete off-then-on cycle is the only way to fully reset the peripheral.

After a request is accepted, the block first clears the 8-bit data bus. On the next clock edge it applies the control pattern for the requested state. It then counts millisecond tick pulses for a settling period, using one parameter for power-off and another for power-on. At the end of that period it samples a synchronised copy of the peripheral's voltage-good signal. A one-cycle completion pulse carries a pass/fail flag. Checking of voltage-good can be switched off separately for each direction. A direction with checking off always reports pass.

Top module: `pwrseq_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it falls, the control lines hold the power-off pattern, the data bus reads 0x00, and busy and done are both low.
- R2: A power-off request (cmd_valid=1, cmd_up=0 sampled while idle) sets busy on the accepting edge. On the following edge it drives {write, data strobe, address strobe, init, irq enable, direction-write} = 6'b111001, with the data bus at 0x00.
- R3: A power-on request (cmd_up=1) follows the same timing as R2 and drives the pattern 6'b000100, with the data bus at 0x00.
- R4: After a power-off pattern is applied, done rises on the edge that samples the DOWN_WAIT_MS-th tick. Only ticks sampled after the edge that applied the pattern are counted, so a tick during the data-clear cycle is not.
- R5: After a power-on pattern is applied, done rises on the edge that samples the UP_WAIT_MS-th tick, counted as in R4.
- R6: With CHECK_DOWN=1, a power-off sequence reports pass=1 only if the synchronised voltage-good is low when the final tick is sampled.
- R7: With CHECK_UP=1, a power-on sequence reports pass=1 only if the synchronised voltage-good is high when the final tick is sampled.
- R8: When checking is disabled for a direction, every sequence in that direction reports pass=1, whatever the level of voltage-good.
- R9: A request that arrives while busy is high is ignored. The control lines keep their pattern, and completion still comes after the original sequence's tick count.
- R10: done is high for exactly one cycle, pass is valid in that cycle, and busy is low from that cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Request strobe, taken only when idle |
| cmd_up | input | 1 | 1 = power on, 0 = power off |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| vgood | input | 1 | Asynchronous voltage-good from the peripheral |
| port_data | output | DATA_W | Port data bus |
| ctl_write | output | 1 | 1 = write cycle asserted |
| ctl_dstrobe | output | 1 | 1 = data strobe asserted |
| ctl_astrobe | output | 1 | 1 = address strobe asserted |
| ctl_init | output | 1 | Supply enable, 1 = peripheral on |
| ctl_irq_en | output | 1 | Interrupt enable |
| ctl_dir_write | output | 1 | 1 = port direction is write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result, valid while done is high |

## Verification
The bench runs power-on and power-off sequences with voltage-good held high and then held low. This pairing separates a correct pass decision from an inverted one in each direction. A second instance with checking disabled runs alongside on the same stimulus and must report pass in every case. Tick counts are probed one tick short of the settling count and again at the count, which exposes off-by-one timers and wrong parameter selection. A stray tick during the data-clear cycle and a request injected mid-settle show whether the block counts too early or lets a second request disturb a sequence in progress.

// File: rtl/pwrseq_pkg.sv
`timescale 1ns/1ps
package pwrseq_pkg;
  typedef enum logic [1:0] {PS_IDLE, PS_CLEAR, PS_SETTLE} pseq_state_t;

  typedef struct packed {
    logic wr;
    logic dstb;
    logic astb;
    logic init;
    logic irq_en;
    logic dir_wr;
  } port_ctl_t;

  localparam port_ctl_t CTL_OFF = '{wr: 1'b1, dstb: 1'b1, astb: 1'b1,
                                    init: 1'b0, irq_en: 1'b0, dir_wr: 1'b1};
  localparam port_ctl_t CTL_ON  = '{wr: 1'b0, dstb: 1'b0, astb: 1'b0,
                                    init: 1'b1, irq_en: 1'b0, dir_wr: 1'b0};
endpackage

// File: rtl/pwrseq_timer.sv
`timescale 1ns/1ps
module pwrseq_timer #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  input  logic          tick,
  output logic          expire
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                         cnt <= '0;
    else if (load)                   cnt <= load_val;
    else if (run && tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expire = run && tick && (cnt == CW'(1));

  // R4
  no_count_up_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !load) |=> (cnt <= $past(cnt)));
endmodule

// File: rtl/pwrseq_lines.sv
`timescale 1ns/1ps
module pwrseq_lines
  import pwrseq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              apply,
  input  logic              go_up,
  output port_ctl_t         ctl,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl  <= CTL_OFF;
      data <= '0;
    end else begin
      if (clear) data <= '0;
      if (apply) ctl  <= go_up ? CTL_ON : CTL_OFF;
    end
  end

  // R9
  lines_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !apply |=> $stable(ctl));
endmodule

// File: rtl/pwrseq_fsm.sv
`timescale 1ns/1ps
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int CW           = 10,
  parameter int DOWN_WAIT_MS = 900,
  parameter int UP_WAIT_MS   = 300,
  parameter bit CHECK_DOWN   = 1'b1,
  parameter bit CHECK_UP     = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic          cmd_up,
  input  logic          expire,
  input  logic          vgood_s,
  output logic          start,
  output logic          apply,
  output logic          go_up,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          run,
  output logic          busy,
  output logic          done,
  output logic          pass
);
  pseq_state_t state;

  assign start    = (state == PS_IDLE) && cmd_valid;
  assign apply    = (state == PS_CLEAR);
  assign load     = apply;
  assign load_val = go_up ? CW'(UP_WAIT_MS) : CW'(DOWN_WAIT_MS);
  assign run      = (state == PS_SETTLE);
  assign busy     = (state != PS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PS_IDLE;
      go_up <= 1'b0;
      done  <= 1'b0;
      pass  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        PS_IDLE: if (cmd_valid) begin
          go_up <= cmd_up;
          state <= PS_CLEAR;
        end
        PS_CLEAR: state <= PS_SETTLE;
        PS_SETTLE: if (expire) begin
          done  <= 1'b1;
          state <= PS_IDLE;
          if (go_up) pass <= CHECK_UP   ? vgood_s  : 1'b1;
          else       pass <= CHECK_DOWN ? !vgood_s : 1'b1;
        end
        default: state <= PS_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
endmodule

// File: rtl/pwrseq_ctrl.sv
`timescale 1ns/1ps
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int DOWN_WAIT_MS = 900,
  parameter int UP_WAIT_MS   = 300,
  parameter bit CHECK_DOWN   = 1'b1,
  parameter bit CHECK_UP     = 1'b1,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_up,
  input  logic              ms_tick,
  input  logic              vgood,
  output logic [DATA_W-1:0] port_data,
  output logic              ctl_write,
  output logic              ctl_dstrobe,
  output logic              ctl_astrobe,
  output logic              ctl_init,
  output logic              ctl_irq_en,
  output logic              ctl_dir_write,
  output logic              busy,
  output logic              done,
  output logic              pass
);
  localparam int MAX_WAIT = (DOWN_WAIT_MS > UP_WAIT_MS) ? DOWN_WAIT_MS : UP_WAIT_MS;
  localparam int CW       = $clog2(MAX_WAIT + 1);

  logic [SYNC_STAGES-1:0] vg_sync;
  logic                   start, apply, go_up, load, run, expire;
  logic [CW-1:0]          load_val;
  port_ctl_t              ctl;

  always_ff @(posedge clk) begin
    if (rst) vg_sync <= '0;
    else     vg_sync <= {vg_sync[SYNC_STAGES-2:0], vgood};
  end

  pwrseq_fsm #(
    .CW(CW), .DOWN_WAIT_MS(DOWN_WAIT_MS), .UP_WAIT_MS(UP_WAIT_MS),
    .CHECK_DOWN(CHECK_DOWN), .CHECK_UP(CHECK_UP)
  ) u_fsm (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_up(cmd_up),
    .expire(expire), .vgood_s(vg_sync[SYNC_STAGES-1]),
    .start(start), .apply(apply), .go_up(go_up), .load(load),
    .load_val(load_val), .run(run), .busy(busy), .done(done), .pass(pass)
  );

  pwrseq_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val),
    .run(run), .tick(ms_tick), .expire(expire)
  );

  pwrseq_lines #(.DATA_W(DATA_W)) u_lines (
    .clk(clk), .rst(rst), .clear(start), .apply(apply), .go_up(go_up),
    .ctl(ctl), .data(port_data)
  );

  assign ctl_write     = ctl.wr;
  assign ctl_dstrobe   = ctl.dstb;
  assign ctl_astrobe   = ctl.astb;
  assign ctl_init      = ctl.init;
  assign ctl_irq_en    = ctl.irq_en;
  assign ctl_dir_write = ctl.dir_wr;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!ctl_init && ctl_write && !busy && !done && port_data == '0));
  // R9
  busy_blocks_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && cmd_valid) |=> $stable(ctl_init));

  generate
    if (!CHECK_DOWN) begin : g_nochk_down
      // R8
      nochk_down_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !ctl_init) |-> pass);
    end
    if (!CHECK_UP) begin : g_nochk_up
      // R8
      nochk_up_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (done && ctl_init) |-> pass);
    end
  endgenerate
endmodule

// File: tb/sim_pwrseq_ctrl.sv
`timescale 1ns/1ps
module sim_pwrseq_ctrl;
  localparam int DW = 5, UW = 3;
  localparam logic [5:0] PAT_OFF = 6'b111001, PAT_ON = 6'b000100;

  logic clk = 1'b0, rst = 1'b1, cmd_valid = 1'b0, cmd_up = 1'b0;
  logic ms_tick = 1'b0, vgood = 1'b0;
  logic [7:0] d0, d1;
  logic w0, ds0, as0, in0, ir0, dr0, b0, dn0, p0;
  logic w1, ds1, as1, in1, ir1, dr1, b1, dn1, p1;
  int checks = 0, failures = 0, done_cnt0 = 0, done_cnt1 = 0;
  bit prev0 = 1'b0, finished = 1'b0;
  logic [1:0] q0[$], q1[$];

  always #2.5 clk = ~clk;

  pwrseq_ctrl #(.DOWN_WAIT_MS(DW), .UP_WAIT_MS(UW)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_up(cmd_up),
    .ms_tick(ms_tick), .vgood(vgood), .port_data(d0), .ctl_write(w0),
    .ctl_dstrobe(ds0), .ctl_astrobe(as0), .ctl_init(in0), .ctl_irq_en(ir0),
    .ctl_dir_write(dr0), .busy(b0), .done(dn0), .pass(p0));

  pwrseq_ctrl #(.DOWN_WAIT_MS(DW), .UP_WAIT_MS(UW),
                .CHECK_DOWN(1'b0), .CHECK_UP(1'b0)) u1 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_up(cmd_up),
    .ms_tick(ms_tick), .vgood(vgood), .port_data(d1), .ctl_write(w1),
    .ctl_dstrobe(ds1), .ctl_astrobe(as1), .ctl_init(in1), .ctl_irq_en(ir1),
    .ctl_dir_write(dr1), .busy(b1), .done(dn1), .pass(p1));

  wire [5:0] lines0 = {w0, ds0, as0, in0, ir0, dr0};
  wire [5:0] lines1 = {w1, ds1, as1, in1, ir1, dr1};

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: accepted request, expected results pushed to the scoreboard
  task automatic issue(input logic up, input logic exp0, input bit tick_in_clear);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_up = up;
    q0.push_back({up, exp0});
    q1.push_back({up, 1'b1});
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(b0 == 1'b1, up ? "R3" : "R2", "busy after accept", b0, 1);
    if (tick_in_clear) ms_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0;
    chk(lines0 == (up ? PAT_ON : PAT_OFF), up ? "R3" : "R2", "pattern",
        lines0, up ? PAT_ON : PAT_OFF);
    chk(d0 == 8'h00, up ? "R3" : "R2", "data bus", d0, 0);
  endtask

  task automatic poke(input logic up);
    @(negedge clk); cmd_valid = 1'b1; cmd_up = up;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ms_tick = 1'b1;
      @(negedge clk); ms_tick = 1'b0;
      repeat (2) @(negedge clk);
    end
    #1;
  endtask

  // Monitor: pops expected results as completions appear
  always @(negedge clk) begin
    if (!rst) begin
      if (dn0 && prev0) chk(1'b0, "R10", "done width", 2, 1);
      prev0 = dn0;
      if (dn0) begin
        logic [1:0] e;
        done_cnt0++;
        chk(b0 == 1'b0, "R10", "busy with done", b0, 0);
        if (q0.size() == 0) chk(1'b0, "R10", "unexpected done u0", 1, 0);
        else begin
          e = q0.pop_front();
          chk(in0 == e[1], "R9", "completed direction", in0, e[1]);
          chk(p0 == e[0], e[1] ? "R7" : "R6", "pass u0", p0, e[0]);
        end
      end
      if (dn1) begin
        logic [1:0] e;
        done_cnt1++;
        if (q1.size() == 0) chk(1'b0, "R8", "unexpected done u1", 1, 0);
        else begin
          e = q1.pop_front();
          chk(p1 == e[0], "R8", "pass with checks off", p1, e[0]);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    chk(1'b0, "WDOG", "watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(lines0 == PAT_OFF && d0 == 8'h00, "R1", "lines in reset", lines0, PAT_OFF);
    rst = 1'b0;
    @(negedge clk);
    chk(lines0 == PAT_OFF, "R1", "lines after reset", lines0, PAT_OFF);
    chk(d0 == 8'h00, "R1", "data after reset", d0, 0);
    chk(b0 == 1'b0 && dn0 == 1'b0, "R1", "busy/done after reset", {b0, dn0}, 0);

    // power on, good supply
    vgood = 1'b1;
    issue(1'b1, 1'b1, 1'b0);
    pulse(UW - 1);
    chk(done_cnt0 == 0, "R5", "early done on", done_cnt0, 0);
    pulse(1);
    chk(done_cnt0 == 1, "R5", "done at up count", done_cnt0, 1);
    @(negedge clk);
    chk(dn0 == 1'b0, "R10", "done dropped", dn0, 0);

    // power off with supply still good: failure when checked; tick in clear cycle
    issue(1'b0, 1'b0, 1'b1);
    pulse(DW - 1);
    chk(done_cnt0 == 1, "R4", "early done off", done_cnt0, 1);
    pulse(1);
    chk(done_cnt0 == 2, "R4", "done at down count", done_cnt0, 2);

    // power on with supply low; request injected mid-settle
    vgood = 1'b0;
    issue(1'b1, 1'b0, 1'b0);
    pulse(1);
    poke(1'b0);
    repeat (2) @(negedge clk);
    chk(lines0 == PAT_ON, "R9", "lines kept during busy", lines0, PAT_ON);
    chk(b0 == 1'b1, "R9", "still busy", b0, 1);
    pulse(UW - 2);
    chk(done_cnt0 == 2, "R9", "no early done", done_cnt0, 2);
    pulse(1);
    chk(done_cnt0 == 3, "R9", "done at original count", done_cnt0, 3);
    repeat (3) @(negedge clk);
    chk(lines0 == PAT_ON && b0 == 1'b0, "R9", "ignored request left no trace",
        {lines0, b0}, {PAT_ON, 1'b0});

    // power off, supply low: pass
    issue(1'b0, 1'b1, 1'b0);
    pulse(DW);
    chk(done_cnt0 == 4, "R6", "done off pass", done_cnt0, 4);

    // power on, good supply again
    vgood = 1'b1;
    repeat (4) @(negedge clk);
    issue(1'b1, 1'b1, 1'b0);
    pulse(UW);
    chk(done_cnt0 == 5, "R7", "done on pass", done_cnt0, 5);

    repeat (4) @(negedge clk);
    chk(done_cnt1 == 5, "R8", "u1 completions", done_cnt1, 5);
    chk(q0.size() == 0 && q1.size() == 0, "R10", "scoreboard drained",
        q0.size() + q1.size(), 0);
    finish_run();
  end
endmodule